// File: doc/BRIEF.md
# Fused Complex Multiply-Accumulate Unit

This block is a fixed-point complex multiply-accumulate datapath for real-time filter arithmetic. Each accepted operand pair (a, b), each component signed two's complement, is multiplied as a complex product. The product is added to a running complex accumulator. The four real partial-product sets are generated as rows of a carry-save reduction. The accumulator feedback is not added by a separate adder after the multiplier. It enters the same reduction as extra rows, so one carry-propagate adder per component closes each operation.

A mode input chooses the operation. In multiply-accumulate mode the feedback rows carry the running result. In plain-multiply mode they are zero, so the output is the bare product. A synchronous clear zeroes the accumulator. Two build choices are set by parameters. The first is the reducer shape: a logarithmic-depth 3:2 compressor tree, or a linear array chain, and both give identical results. The second is an optional register between the reducer and the final adder. In the registered build, back-to-back operands are handled by feeding the registered carry-save pair straight back as the two feedback rows.

Top module: `cmac_unit`

## Requirements
- R1: While `rst` is high at a clock edge, the next cycle shows `out_valid` low and both accumulator outputs zero.
- R2: The real output after an accepted operand equals the previous real accumulator plus a_re*b_re minus a_im*b_im, taken modulo 2^(2N+GUARD).
- R3: The imaginary output after an accepted operand equals the previous imaginary accumulator plus a_re*b_im plus a_im*b_re, taken modulo 2^(2N+GUARD).
- R4: With `acc_en` = 0 (plain-multiply mode), the result written is the complex product alone, and the prior accumulator value has no effect.
- R5: For an operand accepted while `in_valid` is high in cycle c, `out_valid` is high for exactly cycle c+1+PIPE and the outputs change then. `out_valid` is never high otherwise, and the outputs hold when neither a result nor a clear lands.
- R6: Operands accepted on consecutive cycles each accumulate, in order, with no stall and no lost term, in both builds.
- R7: `clr` high with no operand in flight zeroes both accumulator outputs in the next cycle, without raising `out_valid`.
- R8: An operand accepted in the same cycle as `clr` is multiplied without accumulation, and its result is delivered with normal latency.
- R9: With PIPE = 1, `clr` in the cycle after an operand was accepted discards that operand: no `out_valid` and no write follow, and the accumulator reads zero.
- R10: Extreme operands (-2^(N-1) in every component, and -1 in components) give exact products, for example (-2^15)^2 - (-2^15)^2 = 0 and 2*(-2^15)^2 = 2^31 for N = 16.
- R11: The accumulator wraps modulo 2^(2N+GUARD) on overflow, with no saturation.
- R12: The tree reducer (TREE = 1) and the array reducer (TREE = 0) produce bit-identical outputs for identical input streams.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair is accepted this cycle |
| acc_en | input | 1 | 1: multiply-accumulate, 0: plain multiply |
| clr | input | 1 | Synchronous accumulator clear |
| a_re | input | N | Operand a, real part, signed |
| a_im | input | N | Operand a, imaginary part, signed |
| b_re | input | N | Operand b, real part, signed |
| b_im | input | N | Operand b, imaginary part, signed |
| out_valid | output | 1 | A new result was written this cycle |
| acc_re | output | 2N+GUARD | Accumulator real part |
| acc_im | output | 2N+GUARD | Accumulator imaginary part |

## Verification
The bench is built with PIPE = 1, so every result is due two cycles after its operand is accepted, and a clear takes effect in the following cycle. A monitor samples on the falling edge and pairs each `out_valid` pulse, in order, with the model value queued when the operand was driven. A pulse with nothing queued counts as a failure, which covers both spurious and discarded-then-written results. Directed steps check that `out_valid` is low one cycle after an accept and high the next. They read the accumulator one cycle after a clear, and they confirm that no result is left outstanding at the end. A second instance with the array reducer is compared at every result.

// File: rtl/cmac_pkg.sv
package cmac_pkg;

  typedef enum logic {
    MODE_MUL = 1'b0,
    MODE_MAC = 1'b1
  } mode_e;

  // Number of +1 corrections owed by inverted (negated) partial-product rows.
  // First product: only its top row is negative. Second product: when it is
  // subtracted, every row except the top is negative; otherwise only the top.
  function automatic int corr_count(input int n, input bit neg_second);
    return 1 + (neg_second ? (n - 1) : 1);
  endfunction

endpackage

// File: rtl/cmac_rows.sv
module cmac_rows
  import cmac_pkg::*;
#(
  parameter int N    = 16,
  parameter int AW   = 2*N + 4,
  parameter bit NEG2 = 1'b0,
  parameter int NR   = 2*N + 3
) (
  input  logic signed [N-1:0] x0,
  input  logic signed [N-1:0] y0,
  input  logic signed [N-1:0] x1,
  input  logic signed [N-1:0] y1,
  input  logic [AW-1:0]       fb0,
  input  logic [AW-1:0]       fb1,
  output logic [AW-1:0]       rows [NR]
);

  localparam int CORR = corr_count(N, NEG2);

  // One partial-product row. A negated row is the bitwise inverse; its +1 is
  // collected in the shared correction row.
  function automatic logic [AW-1:0] pp(input logic [N-1:0] x, input logic yb,
                                       input int sh, input bit negp);
    logic [AW-1:0] e;
    bit            neg;
    e   = {{(AW-N){x[N-1]}}, x} << sh;
    neg = negp ^ (sh == N - 1);
    if (neg) return yb ? ~e : '1;
    else     return yb ? e  : '0;
  endfunction

  for (genvar i = 0; i < N; i++) begin : g_pp
    assign rows[i]     = pp(x0, y0[i], i, 1'b0);
    assign rows[N + i] = pp(x1, y1[i], i, NEG2);
  end

  assign rows[2*N]     = fb0;
  assign rows[2*N + 1] = fb1;
  assign rows[2*N + 2] = AW'(CORR);

endmodule

// File: rtl/cmac_csa_reduce.sv
module cmac_csa_reduce #(
  parameter int AW   = 36,
  parameter int NR   = 35,
  parameter bit TREE = 1'b1
) (
  input  logic [AW-1:0] rows [NR],
  output logic [AW-1:0] sum,
  output logic [AW-1:0] carry
);

  function automatic logic [2*AW-1:0] csa3(input logic [AW-1:0] a,
                                           input logic [AW-1:0] b,
                                           input logic [AW-1:0] c);
    logic [AW-1:0] cy;
    cy = ((a & b) | (a & c) | (b & c)) << 1;
    return {a ^ b ^ c, cy};
  endfunction

  if (TREE) begin : g_tree
    // Level by level, every full group of three rows becomes two rows.
    always_comb begin
      logic [AW-1:0] v [NR];
      logic [AW-1:0] ts, tc;
      int cnt, g3;
      v   = rows;
      cnt = NR;
      for (int lv = 0; lv < NR; lv++) begin
        if (cnt > 2) begin
          g3 = cnt / 3;
          for (int g = 0; g < NR / 3; g++) begin
            if (g < g3) begin
              {ts, tc}   = csa3(v[3*g], v[3*g + 1], v[3*g + 2]);
              v[2*g]     = ts;
              v[2*g + 1] = tc;
            end
          end
          for (int k = 0; k < 2; k++) begin
            if (3*g3 + k < cnt) v[2*g3 + k] = v[3*g3 + k];
          end
          cnt = 2*g3 + (cnt % 3);
        end
      end
      sum   = v[0];
      carry = v[1];
    end
  end else begin : g_array
    // One compressor per row in a linear chain.
    always_comb begin
      logic [AW-1:0] ts, tc;
      ts = rows[0];
      tc = rows[1];
      for (int i = 2; i < NR; i++) begin
        {ts, tc} = csa3(ts, tc, rows[i]);
      end
      sum   = ts;
      carry = tc;
    end
  end

endmodule

// File: rtl/cmac_unit.sv
module cmac_unit
  import cmac_pkg::*;
#(
  parameter int N     = 16,
  parameter int GUARD = 4,
  parameter bit PIPE  = 1'b1,
  parameter bit TREE  = 1'b1
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic                 acc_en,
  input  logic                 clr,
  input  logic signed [N-1:0]  a_re,
  input  logic signed [N-1:0]  a_im,
  input  logic signed [N-1:0]  b_re,
  input  logic signed [N-1:0]  b_im,
  output logic                 out_valid,
  output logic [2*N+GUARD-1:0] acc_re,
  output logic [2*N+GUARD-1:0] acc_im
);

  localparam int AW = 2*N + GUARD;
  localparam int NR = 2*N + 3;

  logic [1:0][AW-1:0] acc_q;
  logic [1:0][AW-1:0] sum_d;
  logic               fb_zero;
  logic               pend_q;
  logic               commit;

  assign fb_zero = (mode_e'(acc_en) != MODE_MAC) || clr;

  if (PIPE) begin : g_ctl
    always_ff @(posedge clk) begin
      if (rst) pend_q <= 1'b0;
      else     pend_q <= in_valid;
    end
  end else begin : g_ctl
    assign pend_q = 1'b0;
  end

  assign commit = PIPE ? (pend_q && !clr) : in_valid;

  for (genvar gc = 0; gc < 2; gc++) begin : g_comp
    logic signed [N-1:0] x0, y0, x1, y1;
    logic [AW-1:0]       fb0, fb1, rs, rc, ts, tc;
    logic [AW-1:0]       rows [NR];

    // Real: ar*br - ai*bi ; imaginary: ar*bi + ai*br
    assign x0 = a_re;
    assign y0 = (gc == 0) ? b_re : b_im;
    assign x1 = a_im;
    assign y1 = (gc == 0) ? b_im : b_re;

    cmac_rows #(.N(N), .AW(AW), .NEG2(gc == 0), .NR(NR)) u_rows (
      .x0(x0), .y0(y0), .x1(x1), .y1(y1),
      .fb0(fb0), .fb1(fb1), .rows(rows)
    );

    cmac_csa_reduce #(.AW(AW), .NR(NR), .TREE(TREE)) u_red (
      .rows(rows), .sum(rs), .carry(rc)
    );

    if (PIPE) begin : g_pipe
      logic [AW-1:0] s_q, c_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          s_q <= '0;
          c_q <= '0;
        end else if (in_valid) begin
          s_q <= rs;
          c_q <= rc;
        end
      end
      // An operation still in flight is forwarded in carry-save form.
      assign fb0 = fb_zero ? '0 : (pend_q ? s_q : acc_q[gc]);
      assign fb1 = (fb_zero || !pend_q) ? '0 : c_q;
      assign ts  = s_q;
      assign tc  = c_q;
    end else begin : g_flat
      assign fb0 = fb_zero ? '0 : acc_q[gc];
      assign fb1 = '0;
      assign ts  = rs;
      assign tc  = rc;
    end

    assign sum_d[gc] = ts + tc;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q     <= '0;
      out_valid <= 1'b0;
    end else begin
      out_valid <= commit;
      if (commit)   acc_q <= sum_d;
      else if (clr) acc_q <= '0;
    end
  end

  assign acc_re = acc_q[0];
  assign acc_im = acc_q[1];

endmodule

// File: rtl/cmac_check.sv
module cmac_check #(
  parameter bit PIPE = 1'b1,
  parameter int AW   = 36
) (
  input logic          clk,
  input logic          rst,
  input logic          in_valid,
  input logic          clr,
  input logic          out_valid,
  input logic [AW-1:0] acc_re,
  input logic [AW-1:0] acc_im
);

  AST_RESET_CLEARS: assert property (@(posedge clk)
    rst |=> (!out_valid && acc_re == '0 && acc_im == '0)); // R1

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
    (!out_valid && !$past(clr)) |-> ($stable(acc_re) && $stable(acc_im))); // R5

  if (PIPE) begin : g_p
    AST_RESULT_DUE: assert property (@(posedge clk) disable iff (rst)
      (in_valid ##1 !clr) |=> out_valid); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid, 2)); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
      clr |=> (acc_re == '0 && acc_im == '0 && !out_valid)); // R7
  end else begin : g_f
    AST_RESULT_DUE: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid); // R5

    AST_NO_SPURIOUS: assert property (@(posedge clk) disable iff (rst)
      out_valid |-> $past(in_valid)); // R5

    AST_CLEAR_ZEROES: assert property (@(posedge clk) disable iff (rst)
      (clr && !in_valid) |=> (acc_re == '0 && acc_im == '0 && !out_valid)); // R7
  end

endmodule

bind cmac_unit cmac_check #(.PIPE(PIPE), .AW(2*N + GUARD)) u_cmac_check (
  .clk(clk), .rst(rst), .in_valid(in_valid), .clr(clr),
  .out_valid(out_valid), .acc_re(acc_re), .acc_im(acc_im)
);

// File: tb/test_cmac_unit.sv
module test_cmac_unit;

  localparam int N     = 16;
  localparam int GUARD = 4;
  localparam int AW    = 2*N + GUARD;
  localparam bit PIPE  = 1'b1;
  localparam int LAT   = PIPE + 1;
  localparam int QD    = 512;

  // {acc_en, a_re, a_im, b_re, b_im}
  localparam logic [4*N:0] VEC [8] = '{
    {1'b1,  16'sd3,     16'sd4,     16'sd5,     -16'sd2},
    {1'b1, -16'sd7,     16'sd2,     16'sd9,     16'sd11},
    {1'b1,  16'h7fff,   16'h7fff,   16'h7fff,   16'h7fff},
    {1'b1,  16'h8000,   16'h8000,   16'h8000,   16'h8000},
    {1'b0,  16'sd100,  -16'sd50,    16'sd25,    16'sd3},
    {1'b1,  16'hffff,   16'hffff,   16'h8000,   16'h7fff},
    {1'b1,  16'sd1234, -16'sd4321, -16'sd999,   16'sd77},
    {1'b0,  16'h8000,   16'h7fff,   16'h8000,   16'h8000}
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, acc_en = 1'b0, clr = 1'b0;
  logic signed [N-1:0] a_re = '0, a_im = '0, b_re = '0, b_im = '0;
  logic          out_valid, out_valid_arr;
  logic [AW-1:0] acc_re, acc_im, acc_re_arr, acc_im_arr;

  always #2 clk = ~clk;

  cmac_unit #(.N(N), .GUARD(GUARD), .PIPE(PIPE), .TREE(1'b1)) i_cmac_unit (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_en(acc_en), .clr(clr),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid), .acc_re(acc_re), .acc_im(acc_im)
  );

  cmac_unit #(.N(N), .GUARD(GUARD), .PIPE(PIPE), .TREE(1'b0)) i_cmac_unit_arr (
    .clk(clk), .rst(rst), .in_valid(in_valid), .acc_en(acc_en), .clr(clr),
    .a_re(a_re), .a_im(a_im), .b_re(b_re), .b_im(b_im),
    .out_valid(out_valid_arr), .acc_re(acc_re_arr), .acc_im(acc_im_arr)
  );

  int checks = 0, fails = 0;
  int wr = 0, rd = 0;
  logic [AW-1:0] m_re = '0, m_im = '0;
  logic [AW-1:0] q_re [QD];
  logic [AW-1:0] q_im [QD];
  string         q_tag [QD];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [AW-1:0] act, input logic [AW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Result monitor: every out_valid pulse is matched, in order, to the model.
  always @(negedge clk) begin
    if (!rst && out_valid) begin
      if (rd < wr) begin
        chk(acc_re == q_re[rd % QD], q_tag[rd % QD], "real", acc_re, q_re[rd % QD]);
        chk(acc_im == q_im[rd % QD], q_tag[rd % QD], "imag", acc_im, q_im[rd % QD]);
        rd++;
      end else begin
        chk(1'b0, "R5", "out_valid with no result due", AW'(1), AW'(0));
      end
      chk(out_valid_arr && acc_re_arr == acc_re && acc_im_arr == acc_im,
          "R12", "array vs tree real", acc_re_arr, acc_re);
    end
  end

  // Drive one operand for one cycle; update the model and queue the result.
  task automatic op(input bit en, input logic signed [N-1:0] ar,
                    input logic signed [N-1:0] ai, input logic signed [N-1:0] br,
                    input logic signed [N-1:0] bi, input bit c, input bit push,
                    input string tag);
    longint pr, pi;
    logic [63:0] tr, ti;
    in_valid = 1'b1; acc_en = en; clr = c;
    a_re = ar; a_im = ai; b_re = br; b_im = bi;
    pr = longint'(ar) * longint'(br) - longint'(ai) * longint'(bi);
    pi = longint'(ar) * longint'(bi) + longint'(ai) * longint'(br);
    tr = 64'(pr);
    ti = 64'(pi);
    if (push) begin
      if (!en || c) begin m_re = '0; m_im = '0; end
      m_re = m_re + tr[AW-1:0];
      m_im = m_im + ti[AW-1:0];
      q_re[wr % QD] = m_re; q_im[wr % QD] = m_im; q_tag[wr % QD] = tag;
      wr++;
    end
    @(negedge clk);
    in_valid = 1'b0; clr = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0; clr = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic clr_only();
    in_valid = 1'b0; clr = 1'b1;
    m_re = '0; m_im = '0;
    @(negedge clk);
    clr = 1'b0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    chk(1'b0, "R5", "watchdog expired", AW'(rd), AW'(wr));
    summary();
  end

  initial begin
    // R1: reset state
    repeat (3) @(negedge clk);
    chk(!out_valid && acc_re == '0 && acc_im == '0, "R1", "reset state", acc_re, '0);
    rst = 1'b0;
    @(negedge clk);

    // Vector table, driven back to back (R2 R3 R4 R6)
    for (int i = 0; i < 8; i++) begin
      op(VEC[i][4*N], VEC[i][4*N-1 -: N], VEC[i][3*N-1 -: N],
         VEC[i][2*N-1 -: N], VEC[i][N-1 -: N], 1'b0, 1'b1,
         VEC[i][4*N] ? "R2 R3 R6" : "R4");
    end
    idle(4);

    // R5: result due exactly LAT cycles after acceptance
    op(1'b1, 16'sd21, -16'sd13, 16'sd8, 16'sd5, 1'b0, 1'b1, "R5");
    for (int k = 1; k <= LAT; k++) begin
      chk(out_valid == (k == LAT), "R5", "out_valid timing", AW'(out_valid), AW'(k == LAT));
      if (k < LAT) @(negedge clk);
    end
    idle(3);

    // R4: plain multiply after a nonzero accumulator ignores it
    op(1'b0, -16'sd300, 16'sd7, 16'sd45, -16'sd2, 1'b0, 1'b1, "R4");
    idle(3);

    // R7: clear with nothing in flight
    op(1'b1, 16'sd500, 16'sd600, 16'sd700, 16'sd800, 1'b0, 1'b1, "R2 R3");
    idle(3);
    clr_only();
    chk(acc_re == '0 && acc_im == '0 && !out_valid, "R7", "clear zeroes", acc_re, '0);
    idle(2);
    chk(acc_re == '0 && acc_im == '0, "R7", "clear holds", acc_im, '0);

    // R8: operand accepted together with clear
    op(1'b1, 16'sd99, 16'sd98, 16'sd97, 16'sd96, 1'b0, 1'b1, "R2 R3");
    idle(3);
    op(1'b1, -16'sd11, 16'sd22, 16'sd33, -16'sd44, 1'b1, 1'b1, "R8");
    idle(3);

    // R9: clear one cycle after accept discards the operand
    if (PIPE) begin
      op(1'b1, 16'sd1000, 16'sd2000, 16'sd3000, 16'sd4000, 1'b0, 1'b0, "R9");
      clr_only();
      idle(3);
      chk(acc_re == '0 && acc_im == '0, "R9", "discarded operand left no trace", acc_re, '0);
      op(1'b1, 16'sd3, 16'sd2, 16'sd1, 16'sd4, 1'b0, 1'b1, "R9");
      idle(3);
    end

    // R10: extreme operands
    op(1'b0, 16'h8000, 16'h8000, 16'h8000, 16'h8000, 1'b0, 1'b1, "R10");
    idle(3);
    chk(acc_re == '0, "R10", "(-2^15)^2-(-2^15)^2", acc_re, '0);
    chk(acc_im == AW'(64'h8000_0000), "R10", "2*(-2^15)^2", acc_im, AW'(64'h8000_0000));
    op(1'b1, 16'hffff, 16'h8000, 16'hffff, 16'h7fff, 1'b0, 1'b1, "R10");
    op(1'b1, 16'h7fff, 16'hffff, 16'h8000, 16'hffff, 1'b0, 1'b1, "R10");
    idle(3);

    // R11: long run of large products wraps the accumulator
    clr_only();
    for (int i = 0; i < 40; i++) begin
      op(1'b1, 16'h8000, 16'h7fff, 16'h8000, 16'h8000, 1'b0, 1'b1, "R11");
    end
    idle(3);

    // Random stream, mixed modes (R2 R3 R4 R6)
    for (int i = 0; i < 80; i++) begin
      op(1'($urandom), N'($urandom), N'($urandom), N'($urandom), N'($urandom),
         1'b0, 1'b1, "R2 R3 R6");
      if (i % 7 == 0) idle(1);
    end
    idle(6);

    chk(rd == wr, "R5", "all results delivered", AW'(rd), AW'(wr));
    summary();
  end

endmodule